// File: doc/BRIEF.md
# Cycle-Window Sequence Checker

This block watches three sampled single-bit signals and judges one temporal pattern at a time. After a start condition (the `trig` input, or every idle cycle when free-running), the signal `b_in` must be seen high on some clock edge inside a window that opens `MIN_GAP` edges after the start edge. The window closes `MAX_GAP` edges after the start edge, or never when `OPEN_END` is set. Once `b_in` has matched, `c_in` is sampled exactly `FIX_GAP` edges later. The verdict appears as a one-cycle `pass_o` or `fail_o` pulse. While an attempt is running, `busy_o` stays high and further start conditions are dropped.

All timing figures are elaboration-time parameters. A single state register and one shared down-counter carry the attempt. Illegal settings stop elaboration: a negative figure, a closing edge before the opening edge, or a bounded window that opens on the start edge. The synchronous `dis` input abandons any attempt. It is a plain control pin; the block has no data stream, so there is no handshake and no back-pressure.

Top module: `cyc_window_chk`

## Requirements
- R1: While `rst` is high on a clock edge, `busy_o`, `pass_o` and `fail_o` are all low after that edge.
- R2: In bounded mode, with the start on edge t, `b_in` counts as a match on any edge from t+MIN_GAP to t+MAX_GAP inclusive. A `b_in` pulse on an earlier edge is not a match.
- R3: In bounded mode, if `b_in` is low on every edge from t+MIN_GAP to t+MAX_GAP, `fail_o` pulses for the one cycle that follows edge t+MAX_GAP.
- R4: After a match on edge m with FIX_GAP>0, `c_in` is sampled only on edge m+FIX_GAP. High gives a `pass_o` pulse after that edge; low gives a `fail_o` pulse. With FIX_GAP=0, the match itself gives a `pass_o` pulse after edge m.
- R5: With `OPEN_END`=1 the window has no closing edge. If `b_in` never matches, `busy_o` stays high and no verdict is ever given. With MIN_GAP=1, `b_in` is first sampled on edge t+1, and a pulse on edge t is missed.
- R6: With `OPEN_END`=1 and MIN_GAP=0, `b_in` is sampled on the start edge t itself. A match there leaves the block idle if FIX_GAP=0, or gives its verdict after edge t+FIX_GAP otherwise.
- R7: A start condition on any edge where an attempt is already running is ignored. Holding `trig` high through an attempt gives the same verdict and timing as a single-edge `trig`.
- R8: `dis` high on an edge forces the block idle after that edge. No verdict is given after that edge, even when that edge would have produced one, and the abandoned attempt never reports.
- R9: With `FREE_RUN`=1, an attempt starts on every edge where the block is idle, whatever the level of `trig`.
- R10: `pass_o` and `fail_o` each last one cycle and are never high together. `busy_o` is high from the edge that starts an attempt until the edge that gives its verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dis | input | 1 | Synchronous abandon: forces idle and mutes the verdict |
| trig | input | 1 | Start condition, honoured only while idle |
| b_in | input | 1 | Signal expected inside the window |
| c_in | input | 1 | Signal expected FIX_GAP edges after the match |
| pass_o | output | 1 | One-cycle pulse: pattern completed |
| fail_o | output | 1 | One-cycle pulse: window missed or final check low |
| busy_o | output | 1 | High while an attempt is in progress |

## Verification
A wrong state or counter value changes the verdict edge: a pulse one edge early or late, or a pass where a fail belongs. The bench therefore compares `pass_o`, `fail_o` and `busy_o` on every cycle of every attempt against the edge it works out from the offset of the `b_in` pulse. A leftover counter or a missed return to idle shows up as `busy_o` high after the verdict, or as a verdict after `dis`, within one cycle. A hang in open-ended mode is told apart from a lost transition by checking that `busy_o` clears on the edge after `dis`.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WMIN,
    ST_CHK,
    ST_WFIX,
    ST_TAIL
  } cwc_state_e;

  typedef enum logic [1:0] {
    CNT_KEEP,
    CNT_LOAD,
    CNT_DEC,
    CNT_CLR
  } cwc_cnt_op_e;
endpackage

// File: rtl/cwc_counter.sv
module cwc_counter #(
  parameter int W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cwc_pkg::cwc_cnt_op_e op,
  input  logic [W-1:0]         load_val,
  output logic                 zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case (op)
        cwc_pkg::CNT_LOAD: cnt_q <= load_val;
        cwc_pkg::CNT_DEC:  cnt_q <= cnt_q - 1'b1;
        cwc_pkg::CNT_CLR:  cnt_q <= '0;
        default:           cnt_q <= cnt_q;
      endcase
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cwc_step.sv
module cwc_step #(
  parameter int MIN_GAP  = 2,
  parameter int MAX_GAP  = 4,
  parameter int FIX_GAP  = 2,
  parameter bit OPEN_END = 1'b0,
  parameter bit FREE_RUN = 1'b0,
  parameter int CNT_W    = 2
) (
  input  cwc_pkg::cwc_state_e  cur,
  input  logic                 cnt_zero,
  input  logic                 dis,
  input  logic                 trig,
  input  logic                 b_in,
  input  logic                 c_in,
  output cwc_pkg::cwc_state_e  nxt,
  output cwc_pkg::cwc_cnt_op_e op,
  output logic [CNT_W-1:0]     load_val,
  output logic                 pass_n,
  output logic                 fail_n
);
  import cwc_pkg::*;

  localparam bit SAME_EDGE = OPEN_END && (MIN_GAP == 0);
  localparam bit NO_WAIT   = (MIN_GAP <= 1);
  localparam int WIN_LD    = OPEN_END ? 0 : (MAX_GAP - MIN_GAP);
  localparam int MIN_LD    = (MIN_GAP >= 2) ? (MIN_GAP - 2) : 0;
  localparam int FIX_LD    = (FIX_GAP >= 2) ? (FIX_GAP - 2) : 0;

  logic start;
  logic matched;
  logic to_chk;

  assign start = FREE_RUN || trig;

  always_comb begin
    nxt      = cur;
    op       = CNT_KEEP;
    load_val = '0;
    pass_n   = 1'b0;
    fail_n   = 1'b0;
    matched  = 1'b0;
    to_chk   = 1'b0;

    case (cur)
      ST_IDLE: begin
        if (start) begin
          if (SAME_EDGE) begin
            if (b_in) matched = 1'b1;
            else begin
              nxt = ST_CHK;
              op  = CNT_CLR;
            end
          end else if (NO_WAIT) begin
            to_chk = 1'b1;
          end else begin
            nxt      = ST_WMIN;
            op       = CNT_LOAD;
            load_val = CNT_W'(MIN_LD);
          end
        end
      end
      ST_WMIN: begin
        if (cnt_zero) to_chk = 1'b1;
        else op = CNT_DEC;
      end
      ST_CHK: begin
        if (b_in) matched = 1'b1;
        else if (!OPEN_END) begin
          if (cnt_zero) begin
            fail_n = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            op = CNT_DEC;
          end
        end
      end
      ST_WFIX: begin
        if (cnt_zero) nxt = ST_TAIL;
        else op = CNT_DEC;
      end
      ST_TAIL: begin
        pass_n = c_in;
        fail_n = !c_in;
        nxt    = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase

    if (to_chk) begin
      nxt      = ST_CHK;
      op       = CNT_LOAD;
      load_val = CNT_W'(WIN_LD);
    end

    if (matched) begin
      if (FIX_GAP == 0) begin
        nxt    = ST_IDLE;
        pass_n = 1'b1;
      end else if (FIX_GAP == 1) begin
        nxt = ST_TAIL;
      end else begin
        nxt      = ST_WFIX;
        op       = CNT_LOAD;
        load_val = CNT_W'(FIX_LD);
      end
    end

    if (dis) begin
      nxt    = ST_IDLE;
      op     = CNT_CLR;
      pass_n = 1'b0;
      fail_n = 1'b0;
    end
  end
endmodule

// File: rtl/cyc_window_chk.sv
module cyc_window_chk #(
  parameter int MIN_GAP  = 2,
  parameter int MAX_GAP  = 4,
  parameter int FIX_GAP  = 2,
  parameter bit OPEN_END = 1'b0,
  parameter bit FREE_RUN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dis,
  input  logic trig,
  input  logic b_in,
  input  logic c_in,
  output logic pass_o,
  output logic fail_o,
  output logic busy_o
);
  import cwc_pkg::*;

  localparam int WIN_SPAN = OPEN_END ? 0 : (MAX_GAP - MIN_GAP);
  localparam int MIN_SPAN = (MIN_GAP > 2) ? (MIN_GAP - 2) : 0;
  localparam int FIX_SPAN = (FIX_GAP > 2) ? (FIX_GAP - 2) : 0;
  localparam int TOP_A    = (WIN_SPAN > MIN_SPAN) ? WIN_SPAN : MIN_SPAN;
  localparam int TOP_B    = (TOP_A > FIX_SPAN) ? TOP_A : FIX_SPAN;
  localparam int CNT_TOP  = (TOP_B > 1) ? TOP_B : 1;
  localparam int CNT_W    = $clog2(CNT_TOP + 1);

  if (MIN_GAP < 0 || MAX_GAP < 0 || FIX_GAP < 0) begin : g_neg_bound
    $error("cyc_window_chk: timing parameters must be non-negative");
  end
  if (!OPEN_END && MAX_GAP < MIN_GAP) begin : g_bad_order
    $error("cyc_window_chk: closing edge lies before opening edge");
  end
  if (!OPEN_END && MIN_GAP == 0) begin : g_bad_zero
    $error("cyc_window_chk: bounded window may not open on the start edge");
  end

  cwc_state_e           state_q;
  cwc_state_e           state_d;
  cwc_cnt_op_e          cnt_op;
  logic [CNT_W-1:0]     cnt_load;
  logic                 cnt_zero;
  logic                 pass_d;
  logic                 fail_d;

  cwc_step #(
    .MIN_GAP (MIN_GAP),
    .MAX_GAP (MAX_GAP),
    .FIX_GAP (FIX_GAP),
    .OPEN_END(OPEN_END),
    .FREE_RUN(FREE_RUN),
    .CNT_W   (CNT_W)
  ) u_step (
    .cur     (state_q),
    .cnt_zero(cnt_zero),
    .dis     (dis),
    .trig    (trig),
    .b_in    (b_in),
    .c_in    (c_in),
    .nxt     (state_d),
    .op      (cnt_op),
    .load_val(cnt_load),
    .pass_n  (pass_d),
    .fail_n  (fail_d)
  );

  cwc_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .op      (cnt_op),
    .load_val(cnt_load),
    .zero    (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_o  <= pass_d;
      fail_o  <= fail_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/cwc_props.sv
module cwc_props #(
  parameter bit FREE_RUN = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic dis,
  input logic trig,
  input logic pass_o,
  input logic fail_o,
  input logic busy_o
);
  assert_verdict_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));

  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    dis |=> (!busy_o && !pass_o && !fail_o));

  assert_start_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(trig) || FREE_RUN));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!FREE_RUN && !busy_o && !trig) |=> !busy_o);

  assert_verdict_has_attempt_R4: assert property (@(posedge clk) disable iff (rst)
    (pass_o || fail_o) |-> ($past(busy_o) || $past(trig) || FREE_RUN));
endmodule

bind cyc_window_chk cwc_props #(.FREE_RUN(FREE_RUN)) u_props (
  .clk   (clk),
  .rst   (rst),
  .dis   (dis),
  .trig  (trig),
  .pass_o(pass_o),
  .fail_o(fail_o),
  .busy_o(busy_o)
);

// File: tb/test_cyc_window_chk.sv
module test_cyc_window_chk;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_EDGES  = 14;
  localparam int NEVER      = 1000;

  logic       clk = 1'b0;
  logic       rst, dis, b_s, c_s, b3;
  logic [2:0] trg;
  logic [3:0] pw, fw, bw;
  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // unit 0: bounded window 2..4, final check 2 edges after match
  cyc_window_chk #(.MIN_GAP(2), .MAX_GAP(4), .FIX_GAP(2), .OPEN_END(1'b0), .FREE_RUN(1'b0))
    i_cyc_window_chk (.clk(clk), .rst(rst), .dis(dis), .trig(trg[0]), .b_in(b_s), .c_in(c_s),
                      .pass_o(pw[0]), .fail_o(fw[0]), .busy_o(bw[0]));
  // unit 1: open window from the start edge, final check 1 edge after
  cyc_window_chk #(.MIN_GAP(0), .MAX_GAP(0), .FIX_GAP(1), .OPEN_END(1'b1), .FREE_RUN(1'b0))
    i_cyc_window_chk_open0 (.clk(clk), .rst(rst), .dis(dis), .trig(trg[1]), .b_in(b_s), .c_in(c_s),
                            .pass_o(pw[1]), .fail_o(fw[1]), .busy_o(bw[1]));
  // unit 2: open window from edge t+1, no final check
  cyc_window_chk #(.MIN_GAP(1), .MAX_GAP(1), .FIX_GAP(0), .OPEN_END(1'b1), .FREE_RUN(1'b0))
    i_cyc_window_chk_open1 (.clk(clk), .rst(rst), .dis(dis), .trig(trg[2]), .b_in(b_s), .c_in(c_s),
                            .pass_o(pw[2]), .fail_o(fw[2]), .busy_o(bw[2]));
  // unit 3: free-running, single-edge window at t+1
  cyc_window_chk #(.MIN_GAP(1), .MAX_GAP(1), .FIX_GAP(0), .OPEN_END(1'b0), .FREE_RUN(1'b1))
    i_cyc_window_chk_free (.clk(clk), .rst(rst), .dis(1'b0), .trig(1'b0), .b_in(b3), .c_in(1'b0),
                           .pass_o(pw[3]), .fail_o(fw[3]), .busy_o(bw[3]));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic check3(input string tag, input int j, input logic ap, af, ab,
                        input logic ep, ef, eb);
    checks++;
    if (ap !== ep || af !== ef || ab !== eb) begin
      errs++;
      $display("FAIL %s edge %0d: pass/fail/busy got %b%b%b exp %b%b%b",
               tag, j, ap, af, ab, ep, ef, eb);
    end
  endtask

  task automatic unit_cfg(input int u, output int mn, output int mx, output int k, output bit op);
    case (u)
      0:       begin mn = 2; mx = 4; k = 2; op = 1'b0; end
      1:       begin mn = 0; mx = 0; k = 1; op = 1'b1; end
      default: begin mn = 1; mx = 1; k = 0; op = 1'b1; end
    endcase
  endtask

  // One attempt: trigger on edge 0, b_in pulse on edge bpos (-1: none),
  // c_in held at clvl, optional trig hold, optional dis on edge dis_at.
  task automatic run_attempt(input int u, input int bpos, input logic clvl, input bit hold,
                             input int dis_at, input string tag);
    int mn, mx, k, vedge, kind;
    bit op;
    unit_cfg(u, mn, mx, k, op);
    vedge = NEVER;
    kind  = 0;
    if (bpos >= 0 && bpos >= mn && (op || bpos <= mx)) begin
      if (k == 0) begin vedge = bpos; kind = 1; end
      else begin vedge = bpos + k; kind = clvl ? 1 : 2; end
    end else if (!op) begin
      vedge = mx;
      kind  = 2;
    end
    if (dis_at >= 0 && dis_at <= vedge) kind = 0;
    for (int j = 0; j < WIN_EDGES; j++) begin
      logic eb;
      @(negedge clk);
      trg    = '0;
      trg[u] = (j == 0) || (hold && j <= vedge);
      b_s    = (j == bpos);
      c_s    = clvl;
      dis    = (j == dis_at);
      @(posedge clk);
      #(CLK_PERIOD/4);
      eb = (j < vedge) && !(dis_at >= 0 && j >= dis_at);
      check3(tag, j, pw[u], fw[u], bw[u], (kind == 1 && j == vedge), (kind == 2 && j == vedge), eb);
    end
    @(negedge clk);
    trg = '0;
    b_s = 1'b0;
    dis = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check3({tag, " R8 cleanup"}, WIN_EDGES, pw[u], fw[u], bw[u], 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    dis = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish, got hung exp done");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; dis = 1'b0; trg = '0; b_s = 1'b0; c_s = 1'b0; b3 = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    for (int u = 0; u < 4; u++)
      check3("R1 reset", u, pw[u], fw[u], bw[u], 1'b0, 1'b0, 1'b0);

    // R9: free-running unit starts on edge 0, judges on odd edges
    for (int kk = 0; kk < 12; kk++) begin
      logic bv;
      bv = (kk % 3) != 0;
      @(negedge clk);
      rst = 1'b0;
      b3  = bv;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check3("R9 free-run", kk, pw[3], fw[3], bw[3],
             (kk % 2 == 1) && bv, (kk % 2 == 1) && !bv, (kk % 2 == 0));
    end

    // R2 R3 R4 R7: bounded unit, every b_in offset, both c_in levels
    for (int hb = 0; hb < 2; hb++)
      for (int cl = 0; cl < 2; cl++)
        for (int bp = -1; bp <= 6; bp++)
          run_attempt(0, bp, cl[0], hb[0], -1,
                      hb != 0 ? "R7 hold" : ((bp >= 2 && bp <= 4) ? "R2 R4" : "R3"));

    // R6 R5 R4: open window from start edge
    for (int cl = 0; cl < 2; cl++)
      for (int bp = -1; bp <= 8; bp++)
        run_attempt(1, bp, cl[0], 1'b0, -1, bp < 0 ? "R5 open" : "R6 R4");

    // R5 R4: open window from edge t+1, no final check
    for (int bp = -1; bp <= 8; bp++)
      run_attempt(2, bp, 1'b0, bp == 5, -1, bp <= 0 ? "R5 missed" : "R5 R4");

    // R8: abandon on each edge of an attempt that would pass on edge 5
    for (int d = 0; d <= 5; d++)
      run_attempt(0, 3, 1'b1, 1'b0, d, "R8 abandon");
    run_attempt(2, -1, 1'b0, 1'b0, 7, "R8 open");

    report();
    $finish;
  end
endmodule